// File: doc/BRIEF.md
# Early-Warning Interrupt Pulse Filter

This block turns a digitized early-warning comparator flag into an active-low interrupt pulse for a processor. It samples the flag only on a slow sample tick of about 30 kHz, which arrives as a one-cycle strobe in the system clock domain. It fires only after a run of consecutive below-threshold samples, so short dips and supply noise are filtered out in time. A fired pulse is held for a fixed number of ticks. It ends early if the flag is seen back above threshold.

Two further sources can start a pulse. In CMOS mode, software can query the supply level: a falling edge on the strobe input while the flag is below threshold returns a pulse. In NMOS mode, the loss of the supply-in-tolerance flag produces a pulse that always runs to its full timeout. While the supply is not yet valid, below-threshold samples are treated as healthy. After a pulse, the filter stays quiet until the flag has been sampled high again, so a sustained low level gives only one pulse.

Top module: `ewi_pulse_filter`

## Requirements
- R1: While rst_n is low, nmi_n_o is high, the consecutive-low count is zero and the filter is armed.
- R2: A sample is taken only in a cycle with tick_i=1. ew_low_i=1 means below threshold. With the filter armed and vcc_ok_i=1, nmi_n_o goes low (active) at the clock edge of the HITS-th (default 3) consecutive low sample. A sample with ew_low_i=0 clears the run.
- R3: A pulse started by the sample path stays low through the following ticks. It goes high at the edge of the TIMEOUT_TICKS-th (default 7) tick after the firing tick if ew_low_i stays 1.
- R4: A pulse started by the sample path or by a strobe query goes high at the edge of the first tick that samples ew_low_i=0.
- R5: While vcc_ok_i=0, every sample counts as above threshold. After vcc_ok_i rises, a full fresh run of HITS low samples is needed to fire.
- R6: With cmos_mode_i=1, a falling edge on strobe_i while ew_low_i=1 and vcc_ok_i=1 drives nmi_n_o low at the first clock edge at which strobe_i is seen low. If ew_low_i=0 at that edge, no pulse is produced.
- R7: With cmos_mode_i=0, a falling edge on strobe_i produces no pulse.
- R8: With cmos_mode_i=0, a falling edge on vcc_ok_i drives nmi_n_o low at the next edge. Recovery does not end this pulse: it lasts TIMEOUT_TICKS ticks. With cmos_mode_i=1, the same falling edge produces no pulse.
- R9: After a sample-path pulse, the filter does not fire again until a tick has sampled ew_low_i=0. A sustained low level therefore yields one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle sample strobe, about 33 us apart |
| ew_low_i | input | 1 | Early-warning flag, 1 = below threshold |
| vcc_ok_i | input | 1 | Supply-in-tolerance flag, 1 = valid |
| strobe_i | input | 1 | Software strobe level; falling edges are queries |
| cmos_mode_i | input | 1 | 1 = CMOS mode, 0 = NMOS mode |
| nmi_n_o | output | 1 | Active-low interrupt pulse, registered |

## Verification
Every result of this block is due exactly one clock edge after the cycle that presents its cause. A firing or releasing sample shows on nmi_n_o at the edge that ends its tick cycle. A strobe or supply falling edge shows at the first edge at which the new input level is seen. The driver records each expectation with the cycle number of that edge. The monitor compares on the falling clock edge only when that cycle number is reached. Pulse lengths are checked by counting ticks, so the idle cycles between ticks are never mistaken for pulse time.

// File: rtl/ewi_pkg.sv
package ewi_pkg;

  // Which event started the pulse currently on the output.
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_LEVEL  = 2'd1,  // sample run or strobe query: recovery may end it
    CAUSE_SUPPLY = 2'd2   // supply loss: always runs to timeout
  } ewi_cause_e;

  // Next length of the run of low samples, held at cap once reached.
  function automatic int unsigned next_run(int unsigned cur, logic low,
                                           int unsigned cap);
    if (!low) return 0;
    if (cur >= cap) return cap;
    return cur + 1;
  endfunction

  // Tick countdown of an active pulse, never going below zero.
  function automatic int unsigned next_countdown(int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // A supply-loss request takes precedence when events coincide.
  function automatic ewi_cause_e pick_cause(logic supply_req, logic level_req);
    if (supply_req) return CAUSE_SUPPLY;
    if (level_req)  return CAUSE_LEVEL;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/ewi_run_filter.sv
module ewi_run_filter #(
  parameter int unsigned HITS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick_i,
  input  logic                         low_i,
  output logic                         fire_o,
  output logic [$clog2(HITS+1)-1:0]    run_o,
  output logic                         armed_o
);
  import ewi_pkg::*;

  localparam int unsigned CNT_W = $clog2(HITS + 1);
  localparam int unsigned CAP   = HITS - 1;

  logic [CNT_W-1:0] run_q;
  logic             armed_q;

  // R2: fire on the HITS-th consecutive low sample while armed (R9)
  assign fire_o = tick_i && low_i && armed_q && (run_q == CNT_W'(CAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b1;
    end else if (tick_i) begin
      run_q <= CNT_W'(next_run(32'(run_q), low_i, CAP));
      if (!low_i)      armed_q <= 1'b1;   // R9: re-arm on a high sample
      else if (fire_o) armed_q <= 1'b0;
    end
  end

  assign run_o   = run_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/ewi_fall_detect.sv
module ewi_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fall_o
);
  logic prev_q;

  // Previous level resets low so that a low level out of reset is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign fall_o = prev_q && !level_i;

endmodule

// File: rtl/ewi_pulse_timer.sv
module ewi_pulse_timer #(
  parameter int unsigned TIMEOUT_TICKS = 7
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tick_i,
  input  logic                                 start_i,
  input  ewi_pkg::ewi_cause_e                  cause_i,
  input  logic                                 recovered_i,
  output logic                                 active_o,
  output logic [$clog2(TIMEOUT_TICKS+1)-1:0]   left_o
);
  import ewi_pkg::*;

  localparam int unsigned TMR_W = $clog2(TIMEOUT_TICKS + 1);

  logic             active_q;
  logic [TMR_W-1:0] left_q;
  ewi_cause_e       cause_q;
  logic             expire;
  logic             early;

  assign expire = tick_i && (left_q == TMR_W'(1));                             // R3
  assign early  = tick_i && recovered_i && (cause_q == CAUSE_LEVEL);           // R4

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
      cause_q  <= CAUSE_NONE;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        left_q   <= TMR_W'(TIMEOUT_TICKS);
        cause_q  <= cause_i;
      end
    end else if (expire || early) begin
      active_q <= 1'b0;
      left_q   <= '0;
      cause_q  <= CAUSE_NONE;
    end else if (tick_i) begin
      left_q <= TMR_W'(next_countdown(32'(left_q)));
    end
  end

  assign active_o = active_q;
  assign left_o   = left_q;

endmodule

// File: rtl/ewi_pulse_filter.sv
module ewi_pulse_filter #(
  parameter int unsigned HITS          = 3,
  parameter int unsigned TIMEOUT_TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ew_low_i,
  input  logic vcc_ok_i,
  input  logic strobe_i,
  input  logic cmos_mode_i,
  output logic nmi_n_o
);
  import ewi_pkg::*;

  localparam int unsigned CNT_W = $clog2(HITS + 1);
  localparam int unsigned TMR_W = $clog2(TIMEOUT_TICKS + 1);

  // Named internal events, brought out for the checker.
  logic             low_gated;
  logic             fire_sample;
  logic             fire_strobe;
  logic             fire_supply;
  logic             fire_any;
  logic             strobe_fall;
  logic             supply_fall;
  logic             pulse_active;
  logic [CNT_W-1:0] run_len;
  logic             run_armed;
  logic [TMR_W-1:0] pulse_left;
  ewi_cause_e       start_cause;

  // R5: samples while the supply is invalid count as healthy
  assign low_gated = ew_low_i && vcc_ok_i;

  ewi_run_filter #(.HITS(HITS)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .low_i   (low_gated),
    .fire_o  (fire_sample),
    .run_o   (run_len),
    .armed_o (run_armed)
  );

  ewi_fall_detect u_strobe_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (strobe_i),
    .fall_o  (strobe_fall)
  );

  ewi_fall_detect u_supply_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (vcc_ok_i),
    .fall_o  (supply_fall)
  );

  // R6 / R7: strobe query only in CMOS mode with the flag low
  assign fire_strobe = strobe_fall && cmos_mode_i && low_gated;
  // R8: supply-loss pulse only in NMOS mode
  assign fire_supply = supply_fall && !cmos_mode_i;
  assign fire_any    = fire_sample || fire_strobe || fire_supply;
  assign start_cause = pick_cause(fire_supply, fire_sample || fire_strobe);

  ewi_pulse_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .start_i     (fire_any),
    .cause_i     (start_cause),
    .recovered_i (!ew_low_i),
    .active_o    (pulse_active),
    .left_o      (pulse_left)
  );

  assign nmi_n_o = !pulse_active;   // R1: inactive out of reset

endmodule

// File: rtl/ewi_pulse_filter_chk.sv
module ewi_pulse_filter_chk #(
  parameter int unsigned HITS          = 3,
  parameter int unsigned TIMEOUT_TICKS = 7
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               tick_i,
  input logic                               ew_low_i,
  input logic                               vcc_ok_i,
  input logic                               cmos_mode_i,
  input logic                               nmi_n_o,
  input logic                               fire_any,
  input logic [$clog2(HITS+1)-1:0]          run_len,
  input logic [$clog2(TIMEOUT_TICKS+1)-1:0] pulse_left
);
  localparam int unsigned CNT_W = $clog2(HITS + 1);
  localparam int unsigned TMR_W = $clog2(TIMEOUT_TICKS + 1);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> nmi_n_o);

  assert_fall_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_n_o) |-> $past(fire_any));

  assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= CNT_W'(HITS - 1));

  assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_n_o) |-> $past(tick_i));

  assert_countdown_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_left <= TMR_W'(TIMEOUT_TICKS));

  assert_active_has_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n_o |-> (pulse_left != '0));

  assert_early_only_on_recovery_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nmi_n_o) && $past(pulse_left != TMR_W'(1))) |-> $past(!ew_low_i));

  assert_supply_fire_nmos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nmi_n_o) && $past(!vcc_ok_i)) |-> $past(!cmos_mode_i));

endmodule

bind ewi_pulse_filter ewi_pulse_filter_chk #(
  .HITS          (HITS),
  .TIMEOUT_TICKS (TIMEOUT_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .ew_low_i    (ew_low_i),
  .vcc_ok_i    (vcc_ok_i),
  .cmos_mode_i (cmos_mode_i),
  .nmi_n_o     (nmi_n_o),
  .fire_any    (fire_any),
  .run_len     (run_len),
  .pulse_left  (pulse_left)
);

// File: tb/ewi_pulse_filter_bench.sv
module ewi_pulse_filter_bench;

  localparam int TOUT = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic ew_low_i = 1'b0;
  logic vcc_ok_i = 1'b1;
  logic strobe_i = 1'b1;
  logic cmos_mode_i = 1'b0;
  logic nmi_n_o;

  ewi_pulse_filter u_ewi_pulse_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .ew_low_i    (ew_low_i),
    .vcc_ok_i    (vcc_ok_i),
    .strobe_i    (strobe_i),
    .cmos_mode_i (cmos_mode_i),
    .nmi_n_o     (nmi_n_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    due;
    bit    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare each expectation on the falling edge of its due cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (nmi_n_o !== e.val) begin
        fails++;
        $display("FAIL %s: nmi_n_o=%0b expected %0b (cycle %0d)",
                 e.tag, nmi_n_o, e.val, cyc);
      end
    end
  end

  // Expect the output after the coming clock edge.
  task automatic expect_next(bit v, string tag);
    q.push_back('{due: cyc + 1, val: v, tag: tag});
  endtask

  // One sample tick, then one idle cycle.
  task automatic smp(bit low, bit v, string tag);
    @(negedge clk);
    ew_low_i = low;
    tick_i   = 1'b1;
    expect_next(v, tag);
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic hold(bit v, string tag);
    @(negedge clk);
    expect_next(v, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    hold(1'b1, "R1 nmi idle in reset");
    hold(1'b1, "R1 nmi idle in reset");
    @(negedge clk) rst_n = 1'b1;
    hold(1'b1, "R1 nmi idle after reset");

    // R2 / R3: run of three, gaps without tick, full timeout
    smp(1, 1, "R2 first low sample");
    smp(1, 1, "R2 second low sample");
    repeat (4) hold(1'b1, "R2 no sampling without tick");
    smp(1, 0, "R2 fire on third low sample");
    for (int i = 1; i < TOUT; i++) smp(1, 0, "R3 pulse held before timeout");
    smp(1, 1, "R3 release at timeout tick");
    repeat (3) smp(1, 1, "R9 no refire on sustained low");

    // R2 run broken by a high sample; R4 early release
    smp(0, 1, "R9 high sample rearms");
    smp(1, 1, "R2 run 1");
    smp(1, 1, "R2 run 2");
    smp(0, 1, "R2 high sample clears run");
    smp(1, 1, "R2 new run 1");
    smp(1, 1, "R2 new run 2");
    smp(1, 0, "R9 refire after rearm");
    smp(1, 0, "R4 pulse held while low");
    smp(0, 1, "R4 early release on recovery");

    // R8 CMOS supply loss gives no pulse; R5 invalid supply gating
    @(negedge clk) cmos_mode_i = 1'b1;
    @(negedge clk) vcc_ok_i = 1'b0;
    expect_next(1'b1, "R8 cmos supply fall no pulse");
    repeat (2) hold(1'b1, "R8 cmos supply fall no pulse");
    repeat (4) smp(1, 1, "R5 low ignored while supply invalid");
    @(negedge clk) vcc_ok_i = 1'b1;
    smp(1, 1, "R5 fresh run 1");
    smp(1, 1, "R5 fresh run 2");
    smp(1, 0, "R5 fire after fresh run");
    smp(0, 1, "R4 release on recovery");

    // R6 CMOS strobe query
    @(negedge clk);
    ew_low_i = 1'b1;
    strobe_i = 1'b0;
    expect_next(1'b0, "R6 strobe query fires");
    @(negedge clk) strobe_i = 1'b1;
    expect_next(1'b0, "R6 strobe pulse held");
    smp(0, 1, "R4 strobe pulse released on recovery");
    @(negedge clk) strobe_i = 1'b0;
    expect_next(1'b1, "R6 no pulse with input high");
    @(negedge clk) strobe_i = 1'b1;
    expect_next(1'b1, "R6 no pulse with input high");

    // R7 NMOS strobe ignored
    @(negedge clk) cmos_mode_i = 1'b0;
    @(negedge clk);
    ew_low_i = 1'b1;
    strobe_i = 1'b0;
    expect_next(1'b1, "R7 nmos strobe ignored");
    @(negedge clk);
    strobe_i = 1'b1;
    ew_low_i = 1'b0;
    expect_next(1'b1, "R7 nmos strobe ignored");

    // R8 NMOS supply loss pulse runs to timeout despite high samples
    @(negedge clk) vcc_ok_i = 1'b0;
    expect_next(1'b0, "R8 nmos supply fall fires");
    for (int i = 1; i < TOUT; i++) smp(0, 0, "R8 not ended by recovery");
    smp(0, 1, "R8 release at timeout");
    @(negedge clk) vcc_ok_i = 1'b1;
    repeat (3) hold(1'b1, "R8 idle after supply pulse");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: %0d expectations unchecked, expected 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule